// File: doc/BRIEF.md
# Radix-4 LSB-first Modular Multiplier

This block computes `(A * B) mod N` for W-bit operands. It is built for the inner loop of a modular exponentiation engine. Two multiplier bits are consumed per clock, starting from the least significant end, so a multiplication takes W/2 iterations. The running summand starts at A and is multiplied by four after every iteration. The partial product is kept in carry-save form, so no carry propagates through an iteration.

Reduction never compares against N. Any weight that spills above bit W-1 is counted. The block then substitutes a residue from a small constant table that the caller supplies: entry j holds `(j * 2^W) mod N` for j = 1..6. Two short fold cycles at the end resolve the carry-save value into binary. A single borrow test then brings the result below N.

The input side is a one-deep handshake. `ready_o` is high while the block is idle, and a cycle with `start_i` and `ready_o` both high accepts A and B. `mod_i` and `ktab_i` are not captured, so the caller holds them stable until `done_o`. The result side has no back-pressure: `done_o` pulses once, and `prod_o` holds the result until the next result replaces it.

Top module: `modmul_r4`

## Requirements
- R1: With `mod_i` having bit W-1 set and `ktab_i` entry j (bits j*W-1 down to (j-1)*W) equal to `(j * 2^W) mod mod_i`, the result is `(a_i * b_i) mod mod_i` and is strictly below `mod_i`. Here `a_i` and `b_i` are any W-bit values, including values at or above `mod_i`.
- R2: `done_o` rises W/2+2 clock edges after the accepting edge, which is one edge per pair of multiplier bits plus two resolution edges.
- R3: `done_o` is high for exactly one cycle per accepted operation.
- R4: `ready_o` is high exactly when no operation is in flight, and is high in the `done_o` cycle. A `start_i` while `ready_o` is low is ignored: the running result is unchanged and no extra `done_o` follows.
- R5: `prod_o` changes only in a cycle where `done_o` is high. Between results it holds its value even when the operand inputs change.
- R6: A synchronous reset (`rst_ni` low at a clock edge) sets `ready_o` to 1, `done_o` to 0 and `prod_o` to 0. This holds even when the reset arrives during an operation.
- R7: Edge operands give the exact residue. A zero operand gives 0. `(N-1)*(N-1)` gives 1. All-ones operands with the smallest legal modulus `2^(W-1)+1` give the correct residue even though both exceed N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to start; accepted when `ready_o` is high |
| ready_o | output | 1 | Idle; a start in this cycle is taken |
| a_i | input | W | Multiplicand, captured on accept |
| b_i | input | W | Multiplier, captured on accept |
| mod_i | input | W | Modulus, bit W-1 set, held while busy |
| ktab_i | input | 6*W | Residues of j*2^W mod N, entry j at bits j*W-1:(j-1)*W |
| prod_o | output | W | Result, valid from the `done_o` cycle onward |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench aims at the places where the overflow substitution is under the most stress. All-ones operands against the smallest legal modulus keep the summand's top two bits set in almost every iteration. A design that drops the second table fold, or uses the wrong overflow weight, returns a value that is off by a multiple of 2^W mod N, or one that is not below N. `(N-1)^2` checks the final borrow test: a wrong subtraction leaves N+1 instead of 1. A start pulse is sent mid-operation with different operands, which exposes a block that restarts or captures the new values. The exact cycle of `done_o` is also checked, and it would shift if an iteration retired only one bit.

// File: rtl/modmul_r4_pkg.sv
package modmul_r4_pkg;

  // Number of overflow residues supplied by the caller (weights 1..KTAB_N).
  localparam int unsigned KTAB_N = 6;
  // Width of an overflow-weight index (0..KTAB_N).
  localparam int unsigned KIDX_W = $clog2(KTAB_N + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FOLD,
    ST_FIX
  } mm_state_e;

endpackage

// File: rtl/modmul_r4_csa.sv
// Three-to-two carry-save compressor over WD bits.
module modmul_r4_csa #(
  parameter int unsigned WD = 8
) (
  input  logic [WD-1:0] x_i,
  input  logic [WD-1:0] y_i,
  input  logic [WD-1:0] z_i,
  output logic [WD-1:0] sum_o,
  output logic [WD-1:0] carry_o
);

  logic [WD-1:0] maj;

  assign sum_o   = x_i ^ y_i ^ z_i;
  assign maj     = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
  assign carry_o = {maj[WD-2:0], 1'b0};

endmodule

// File: rtl/modmul_r4_ksel.sv
// Picks the residue for an overflow weight; weight 0 yields zero.
module modmul_r4_ksel
  import modmul_r4_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [KIDX_W-1:0]   idx_i,
  input  logic [KTAB_N*W-1:0] tbl_i,
  output logic [W-1:0]        val_o
);

  always_comb begin
    val_o = '0;
    for (int j = 1; j <= KTAB_N; j++) begin
      if (idx_i == KIDX_W'(j)) val_o = tbl_i[(j-1)*W +: W];
    end
  end

endmodule

// File: rtl/modmul_r4_accum.sv
// One radix-4 iteration of the partial product in carry-save form.
// Addends: ps, pc, pending residue pk, b0*S and the low W bits of b1*2S.
// Everything that lands at or above bit W (plus the dropped top bit of 2S)
// becomes an overflow weight (at most 5) and is replaced by its residue.
module modmul_r4_accum
  import modmul_r4_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]        ps_i,
  input  logic [W-1:0]        pc_i,
  input  logic [W-1:0]        pk_i,
  input  logic [W-1:0]        sm_i,
  input  logic [1:0]          bits_i,
  input  logic [KTAB_N*W-1:0] tbl_i,
  output logic [W-1:0]        ps_o,
  output logic [W-1:0]        pc_o,
  output logic [W-1:0]        pk_o
);

  localparam int unsigned XW = W + 3;

  logic [XW-1:0] ps_x, pc_x, pk_x, a1_x, a2_x;
  logic [XW-1:0] s1, c1, s2, c2, s3, c3;
  logic [2:0]    wt;

  assign ps_x = XW'(ps_i);
  assign pc_x = XW'(pc_i);
  assign pk_x = XW'(pk_i);
  assign a1_x = bits_i[0] ? XW'(sm_i) : '0;
  assign a2_x = bits_i[1] ? XW'({sm_i[W-2:0], 1'b0}) : '0;

  modmul_r4_csa #(.WD(XW)) csa_a (.x_i(ps_x), .y_i(pc_x), .z_i(pk_x), .sum_o(s1), .carry_o(c1));
  modmul_r4_csa #(.WD(XW)) csa_b (.x_i(s1),   .y_i(c1),   .z_i(a1_x), .sum_o(s2), .carry_o(c2));
  modmul_r4_csa #(.WD(XW)) csa_c (.x_i(s2),   .y_i(c2),   .z_i(a2_x), .sum_o(s3), .carry_o(c3));

  assign wt = s3[XW-1:W] + c3[XW-1:W] + {2'b00, bits_i[1] & sm_i[W-1]};

  modmul_r4_ksel #(.W(W)) ksel_i (
    .idx_i (KIDX_W'(wt)),
    .tbl_i (tbl_i),
    .val_o (pk_o)
  );

  assign ps_o = s3[W-1:0];
  assign pc_o = c3[W-1:0];

endmodule

// File: rtl/modmul_r4_summand.sv
// Summand update S <- 4S, kept below 2^W. The two bits shifted out select a
// residue; a carry out of that sum is folded once more with the weight-1
// residue. Given bit W-1 of N set, the second fold cannot overflow.
module modmul_r4_summand
  import modmul_r4_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]        sm_i,
  input  logic [KTAB_N*W-1:0] tbl_i,
  output logic [W-1:0]        sm_o
);

  logic [W-1:0] k_hi;
  logic [W:0]   first;

  modmul_r4_ksel #(.W(W)) ksel_i (
    .idx_i (KIDX_W'(sm_i[W-1:W-2])),
    .tbl_i (tbl_i),
    .val_o (k_hi)
  );

  assign first = {1'b0, sm_i[W-3:0], 2'b00} + {1'b0, k_hi};
  assign sm_o  = first[W] ? (first[W-1:0] + tbl_i[W-1:0]) : first[W-1:0];

endmodule

// File: rtl/modmul_r4_resolve.sv
// Final resolution. Fold stage: ps+pc+pk to binary, overflow weight (<=2)
// swapped for its residue. Fix stage: one more weight-1 fold if needed,
// then a single borrow-tested subtraction of N.
module modmul_r4_resolve
  import modmul_r4_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]        ps_i,
  input  logic [W-1:0]        pc_i,
  input  logic [W-1:0]        pk_i,
  input  logic [W:0]          fold_i,
  input  logic [W-1:0]        mod_i,
  input  logic [KTAB_N*W-1:0] tbl_i,
  output logic [W:0]          fold_o,
  output logic [W-1:0]        res_o
);

  logic [W+1:0] whole;
  logic [W-1:0] k_hi;
  logic [W-1:0] near;
  logic [W:0]   diff;

  assign whole = (W+2)'(ps_i) + (W+2)'(pc_i) + (W+2)'(pk_i);

  modmul_r4_ksel #(.W(W)) ksel_i (
    .idx_i (KIDX_W'(whole[W+1:W])),
    .tbl_i (tbl_i),
    .val_o (k_hi)
  );

  assign fold_o = {1'b0, whole[W-1:0]} + {1'b0, k_hi};

  assign near  = fold_i[W] ? (fold_i[W-1:0] + tbl_i[W-1:0]) : fold_i[W-1:0];
  assign diff  = {1'b0, near} - {1'b0, mod_i};
  assign res_o = diff[W] ? near : diff[W-1:0];

endmodule

// File: rtl/modmul_r4.sv
module modmul_r4
  import modmul_r4_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic                ready_o,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic [W-1:0]        mod_i,
  input  logic [KTAB_N*W-1:0] ktab_i,
  output logic [W-1:0]        prod_o,
  output logic                done_o
);

  localparam int unsigned ITER = W / 2;
  localparam int unsigned CW   = $clog2(ITER + 1);

  mm_state_e     state_q;
  logic [W-1:0]  sm_q, mb_q, ps_q, pc_q, pk_q, prod_q;
  logic [CW-1:0] it_q;
  logic [W:0]    fold_q;
  logic          done_q;

  logic [W-1:0]  sm_nx, ps_nx, pc_nx, pk_nx, res_nx;
  logic [W:0]    fold_nx;

  modmul_r4_summand #(.W(W)) summand_i (
    .sm_i  (sm_q),
    .tbl_i (ktab_i),
    .sm_o  (sm_nx)
  );

  modmul_r4_accum #(.W(W)) accum_i (
    .ps_i   (ps_q),
    .pc_i   (pc_q),
    .pk_i   (pk_q),
    .sm_i   (sm_q),
    .bits_i (mb_q[1:0]),
    .tbl_i  (ktab_i),
    .ps_o   (ps_nx),
    .pc_o   (pc_nx),
    .pk_o   (pk_nx)
  );

  modmul_r4_resolve #(.W(W)) resolve_i (
    .ps_i   (ps_q),
    .pc_i   (pc_q),
    .pk_i   (pk_q),
    .fold_i (fold_q),
    .mod_i  (mod_i),
    .tbl_i  (ktab_i),
    .fold_o (fold_nx),
    .res_o  (res_nx)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sm_q    <= '0;
      mb_q    <= '0;
      ps_q    <= '0;
      pc_q    <= '0;
      pk_q    <= '0;
      it_q    <= '0;
      fold_q  <= '0;
      prod_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sm_q    <= a_i;
            mb_q    <= b_i;
            ps_q    <= '0;
            pc_q    <= '0;
            pk_q    <= '0;
            it_q    <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          sm_q <= sm_nx;
          mb_q <= mb_q >> 2;
          ps_q <= ps_nx;
          pc_q <= pc_nx;
          pk_q <= pk_nx;
          it_q <= it_q + CW'(1);
          if (it_q == CW'(ITER - 1)) state_q <= ST_FOLD;
        end
        ST_FOLD: begin
          fold_q  <= fold_nx;
          state_q <= ST_FIX;
        end
        ST_FIX: begin
          prod_q  <= res_nx;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign prod_o  = prod_q;
  assign done_o  = done_q;

endmodule

// File: rtl/modmul_r4_chk.sv
module modmul_r4_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         ready_o,
  input logic         done_o,
  input logic [W-1:0] mod_i,
  input logic [W-1:0] prod_o
);

  localparam int unsigned LAT = W / 2 + 2;

  logic        busy_q;
  logic [15:0] cyc_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
    end else if (start_i && ready_o) begin
      busy_q <= 1'b1;
      cyc_q  <= '0;
    end else if (busy_q) begin
      cyc_q <= cyc_q + 16'd1;
      if (done_o) busy_q <= 1'b0;
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_q && cyc_q == 16'(LAT))); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3

  AST_RESULT_BELOW_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (prod_o < mod_i)); // R1

  AST_BUSY_BLOCKS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |-> !ready_o); // R4

  AST_READY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o); // R4

  AST_PROD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(prod_o)); // R5

endmodule

bind modmul_r4 modmul_r4_chk #(.W(W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ready_o (ready_o),
  .done_o  (done_o),
  .mod_i   (mod_i),
  .prod_o  (prod_o)
);

// File: tb/modmul_r4_tb_top.sv
module modmul_r4_tb_top;

  localparam int unsigned W          = 32;
  localparam int unsigned KN         = 6;
  localparam int unsigned CLK_PERIOD = 10;
  // Start driven at a negedge; done is set by edge W/2+2 after the accepting
  // edge, so it is seen at the (W/2+3)-th negedge that follows.
  localparam int unsigned EXP_WAIT   = W / 2 + 3;
  localparam int          NVEC       = 8;

  // {A, B, N}
  localparam logic [95:0] VEC [NVEC] = '{
    {32'h0000_0005, 32'h0000_0007, 32'h8000_0001},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hF123_4567},  // R7 zero A
    {32'hFFFF_FFFF, 32'h0000_0000, 32'hC000_0003},  // R7 zero B
    {32'hFFFF_FFFA, 32'hFFFF_FFFA, 32'hFFFF_FFFB},  // R7 (N-1)^2
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0001},  // R7 all ones, least N
    {32'h0000_0001, 32'hDEAD_BEEF, 32'h9E37_79B9},
    {32'h1234_5678, 32'h9ABC_DEF0, 32'hC000_0003},
    {32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             ready;
  logic [W-1:0]     a = '0, b = '0, n = 32'h8000_0001;
  logic [KN*W-1:0]  ktab = '0;
  logic [W-1:0]     prod;
  logic             done;

  int checks = 0;
  int errors = 0;

  modmul_r4 #(.W(W)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .ready_o (ready),
    .a_i     (a),
    .b_i     (b),
    .mod_i   (n),
    .ktab_i  (ktab),
    .prod_o  (prod),
    .done_o  (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic [W-1:0] m);
    logic [63:0] p;
    p = 64'(x) * 64'(y);
    return W'(p % 64'(m));
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_mod(input logic [W-1:0] m);
    n = m;
    for (int j = 1; j <= int'(KN); j++)
      ktab[(j-1)*W +: W] = W'((64'(j) << W) % 64'(m));
  endtask

  // Full operation: drive at negedge, wait for done, check value and timing.
  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [W-1:0] m, input string tag);
    int waited;
    logic [W-1:0] got;
    @(negedge clk);
    a = x; b = y; set_mod(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 1;
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    got = prod;
    check({tag, " R1 result"}, 64'(got), 64'(ref_mul(x, y, m)));
    check({tag, " R2 latency"}, 64'(waited), 64'(EXP_WAIT));
    @(negedge clk);
    check({tag, " R3 done drops"}, 64'(done), 64'd0);
    check({tag, " R5 prod held"}, 64'(prod), 64'(got));
  endtask

  initial begin
    repeat (3000 * 20) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual no finish expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 ready in reset", 64'(ready), 64'd1);
    check("R6 done in reset", 64'(done), 64'd0);
    check("R6 prod in reset", 64'(prod), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++)
      run_op(VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], "R1 R7 vector");

    for (int i = 0; i < 30; i++)
      run_op($urandom, $urandom, $urandom | 32'h8000_0001, "R1 random");

    // R4: a second start while busy is ignored
    begin
      int waited;
      int dones;
      logic [W-1:0] exp;
      exp = ref_mul(32'h8765_4321, 32'hFEDC_BA98, 32'hE000_0011);
      @(negedge clk);
      a = 32'h8765_4321; b = 32'hFEDC_BA98; set_mod(32'hE000_0011);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waited = 1;
      repeat (3) begin @(negedge clk); waited++; end
      check("R4 ready low while busy", 64'(ready), 64'd0);
      a = 32'h1111_1111; b = 32'h2222_2222;
      start = 1'b1;
      @(negedge clk);
      waited++;
      start = 1'b0;
      while (!done && waited < 200) begin
        @(negedge clk);
        waited++;
      end
      check("R4 busy start ignored, result", 64'(prod), 64'(exp));
      check("R4 busy start ignored, latency", 64'(waited), 64'(EXP_WAIT));
      check("R4 ready with done", 64'(ready), 64'd1);
      dones = 0;
      repeat (EXP_WAIT + 4) begin
        @(negedge clk);
        if (done) dones++;
      end
      check("R4 no extra done", 64'(dones), 64'd0);
      // R5: operand changes without start leave the result alone
      check("R5 prod held after idle", 64'(prod), 64'(exp));
    end

    // R6: reset in the middle of an operation
    @(negedge clk);
    a = 32'h0F0F_0F0F; b = 32'h3333_3333; set_mod(32'hB000_0007);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 ready after mid reset", 64'(ready), 64'd1);
    check("R6 done after mid reset", 64'(done), 64'd0);
    check("R6 prod after mid reset", 64'(prod), 64'd0);
    rst_n = 1'b1;
    run_op(32'h0F0F_0F0F, 32'h3333_3333, 32'hB000_0007, "R1 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule